// File: doc/BRIEF.md
# Infrared Pulse-Width Frame Transmitter

The block turns one data word into a frame of timed pulses on a single infrared output line. A frame is an optional leading marker pulse, then one pulse for each data bit (least significant bit first), then an optional closing pulse. Every pulse has a first and a second phase. By default the first phase drives the active level and the second phase drives the idle level. Each phase length is an 8-bit field counted in units of a programmable prescaled clock. The four pulse kinds (leader, logic 0, logic 1, closer) each have their own pair of lengths and their own swap flag.

Data words enter a small FIFO through a valid/ready handshake. While the enable input is high, each word is taken out as one frame. Between frames the line rests at the idle level for as long as a closing pulse lasts, unless back-to-back mode is selected. An optional carrier can replace the active level with a square wave. Three flags report the state of the transmitter: frame complete, FIFO at or below a threshold, and FIFO misuse. Each flag can be enabled onto a single interrupt line.

Top module: `irpw_tx`

## Requirements
- R1: A frame is sent as the leader pulse (when `cfg_head_en`=1), then `cfg_nbits`+1 data pulses starting from bit 0 of the word, then the closer pulse (when `cfg_tail_en`=1). A data bit of 1 uses the logic-1 pulse and a data bit of 0 uses the logic-0 pulse.
- R2: A phase with field value N lasts (N+1)×(`cfg_unit`+1) clock cycles. `cfg_widths` holds eight bytes, from the low byte upward: leader phase 0, leader phase 1, logic-0 phase 0, logic-0 phase 1, logic-1 phase 0, logic-1 phase 1, closer phase 0, closer phase 1.
- R3: Phase 0 is active and phase 1 is idle. Bit i of `cfg_inv` (0 leader, 1 logic 0, 2 logic 1, 3 closer) swaps the two phases of that pulse kind.
- R4: Outside a frame `ir_out` equals `cfg_out_inv`. The active level is its complement.
- R5: With `cfg_cont`=0, the next frame begins after (closer phase 0 + closer phase 1 + 2)×(`cfg_unit`+1) idle cycles. With `cfg_cont`=1, it begins on the cycle after the last phase ends.
- R6: With `cfg_mod_en`=1, every run of active cycles starts a carrier that is active for `cfg_mod_hi`+1 cycles and idle for `cfg_mod_lo`+1 cycles, repeating for as long as the run lasts.
- R7: Each word is cut to 8×(`cfg_fifo_w`+1) bits (code 3 means 32). Data bits above that width are sent as 0.
- R8: `in_ready` is high while the FIFO (4 entries by default) is not full. `fifo_cnt` gives the number of stored words, and a write offered while the FIFO is full is dropped.
- R9: `int_sts[1]` is high exactly when `fifo_cnt` <= `cfg_thresh`.
- R10: `int_sts[2]` is set by a write offered while the FIFO is full, or by a frame ending in back-to-back mode while enabled with the FIFO empty. It stays set until cleared by `int_clr[2]`.
- R11: `int_sts[0]` is set when a frame finishes and stays set until cleared by `int_clr[0]`. A set and a clear in the same cycle leave the flag set.
- R12: `irq` is the OR of `int_sts & cfg_int_en`.
- R13: When idle, with `tx_en` high and the FIFO not empty, the first phase starts on the next clock edge. With `tx_en` low the line stays idle and the FIFO is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_unit | input | 16 | Unit length minus one, in cycles |
| cfg_widths | input | 64 | Eight phase-length bytes |
| cfg_inv | input | 4 | Per pulse-kind phase swap |
| cfg_head_en | input | 1 | Send leader pulse |
| cfg_tail_en | input | 1 | Send closer pulse |
| cfg_nbits | input | 5 | Data bits per frame minus one |
| cfg_fifo_w | input | 2 | Word width code |
| cfg_out_inv | input | 1 | Idle level |
| cfg_cont | input | 1 | Back-to-back frames |
| cfg_mod_en | input | 1 | Carrier enable |
| cfg_mod_hi | input | 8 | Carrier active length minus one |
| cfg_mod_lo | input | 8 | Carrier idle length minus one |
| cfg_thresh | input | 3 | FIFO threshold level |
| cfg_int_en | input | 3 | Interrupt enables |
| int_clr | input | 3 | Flag clears |
| tx_en | input | 1 | Transmit enable |
| in_data | input | 32 | Write data |
| in_valid | input | 1 | Write request |
| in_ready | output | 1 | FIFO can accept |
| ir_out | output | 1 | Infrared output line |
| busy | output | 1 | Frame or gap in progress |
| fifo_cnt | output | 3 | Stored words |
| int_sts | output | 3 | {misuse, threshold, frame complete} |
| irq | output | 1 | Interrupt |

## Verification
The assertions check, on every cycle, that the line stays at the idle level outside a frame, that the phase counter never passes its limit, that the FIFO is never popped while empty and never counts past its depth, that the carrier restarts high after each idle run, and that a finished frame raises its flag. Whether every pulse has the right length, order, swap and carrier pattern can only be shown by the bench. It does this by comparing the whole waveform, cycle by cycle, against a model built from the configuration. The gap between frames, the back-to-back underrun, word-width masking and the flag and interrupt handling are also covered only by the bench scenarios.

// File: rtl/irpw_pkg.sv
package irpw_pkg;

  localparam int DATA_W  = 32;
  localparam int FIELD_W = 8;
  localparam int GAP_W   = FIELD_W + 1;
  localparam int NFIELD  = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} tx_state_e;
  typedef enum logic [1:0] {SK_HEAD, SK_DATA, SK_TAIL} sym_kind_e;

  localparam logic [1:0] PT_HEAD = 2'd0;
  localparam logic [1:0] PT_ZERO = 2'd1;
  localparam logic [1:0] PT_ONE  = 2'd2;
  localparam logic [1:0] PT_TAIL = 2'd3;

  // valid bits of a word for a width code
  function automatic logic [DATA_W-1:0] entry_mask(input logic [1:0] fw);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < 8 * (int'(fw) + 1)) m[i] = 1'b1;
    end
    return m;
  endfunction

  // last unit index of one phase of one pulse kind
  function automatic logic [FIELD_W-1:0] phase_units(input logic [NFIELD*FIELD_W-1:0] w,
                                                     input logic [1:0] pt, input logic ph);
    logic [5:0] base;
    base = {pt, ph, 3'b000};
    return w[base +: FIELD_W];
  endfunction

  // last unit index of the inter-frame gap: closer length minus one unit
  function automatic logic [GAP_W-1:0] gap_last(input logic [NFIELD*FIELD_W-1:0] w);
    return GAP_W'(w[6*FIELD_W +: FIELD_W]) + GAP_W'(w[7*FIELD_W +: FIELD_W]) + GAP_W'(1);
  endfunction

  // pulse kind of the current symbol
  function automatic logic [1:0] pulse_kind(input sym_kind_e k, input logic bit_val);
    case (k)
      SK_HEAD: return PT_HEAD;
      SK_TAIL: return PT_TAIL;
      default: return bit_val ? PT_ONE : PT_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/irpw_fifo.sv
module irpw_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push, pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push    = wr_en && !full;
  assign pop     = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R8
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty); // R8

endmodule

// File: rtl/irpw_unit_tick.sv
module irpw_unit_tick #(
  parameter int UW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [UW-1:0] unit,
  output logic          tick
);
  logic [UW-1:0] cnt_q;

  assign tick = !hold && (cnt_q == unit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (hold || tick)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + UW'(1);
  end

  AST_TICK_FIRST_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !$past(hold) && unit != '0) |=> !tick || hold); // R2

endmodule

// File: rtl/irpw_carrier.sv
module irpw_carrier #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [LW-1:0] hi_len,
  input  logic [LW-1:0] lo_len,
  output logic          car
);
  logic          low_q;
  logic [LW-1:0] cnt_q;
  logic          flip;

  assign car  = !low_q;
  assign flip = low_q ? (cnt_q == lo_len) : (cnt_q == hi_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en) begin
      low_q <= 1'b0;
      cnt_q <= '0;
    end else if (flip) begin
      low_q <= !low_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + LW'(1);
    end
  end

  AST_CAR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> car); // R6

endmodule

// File: rtl/irpw_tx.sv
module irpw_tx
  import irpw_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int UW    = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [UW-1:0]             cfg_unit,
  input  logic [NFIELD*FIELD_W-1:0] cfg_widths,
  input  logic [3:0]                cfg_inv,
  input  logic                      cfg_head_en,
  input  logic                      cfg_tail_en,
  input  logic [4:0]                cfg_nbits,
  input  logic [1:0]                cfg_fifo_w,
  input  logic                      cfg_out_inv,
  input  logic                      cfg_cont,
  input  logic                      cfg_mod_en,
  input  logic [FIELD_W-1:0]        cfg_mod_hi,
  input  logic [FIELD_W-1:0]        cfg_mod_lo,
  input  logic [CW-1:0]             cfg_thresh,
  input  logic [2:0]                cfg_int_en,
  input  logic [2:0]                int_clr,
  input  logic                      tx_en,
  input  logic [DATA_W-1:0]         in_data,
  input  logic                      in_valid,
  output logic                      in_ready,
  output logic                      ir_out,
  output logic                      busy,
  output logic [CW-1:0]             fifo_cnt,
  output logic [2:0]                int_sts,
  output logic                      irq
);

  // ---------------- FIFO ----------------
  logic [DATA_W-1:0] fifo_rd;
  logic              fifo_full, fifo_empty;
  logic              start_ev;

  irpw_fifo #(.W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(in_valid), .wr_data(in_data),
    .rd_en(start_ev), .rd_data(fifo_rd),
    .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
  );
  assign in_ready = !fifo_full;

  // ---------------- sequencer state ----------------
  tx_state_e         state_q;
  sym_kind_e         sym_q;
  logic              phase_q;
  logic [GAP_W-1:0]  ucnt_q;
  logic [4:0]        bitcnt_q;
  logic [DATA_W-1:0] shreg_q;

  logic unit_tick;
  irpw_unit_tick #(.UW(UW)) u_tick (
    .clk(clk), .rst_n(rst_n), .hold(state_q == ST_IDLE),
    .unit(cfg_unit), .tick(unit_tick)
  );

  // named events
  logic [1:0]       ptype;
  logic [GAP_W-1:0] lim;
  logic             phase_end, last_sym, frame_done, gap_done, can_start, underrun;

  assign ptype      = pulse_kind(sym_q, shreg_q[0]);
  assign lim        = (state_q == ST_GAP) ? gap_last(cfg_widths)
                                          : GAP_W'(phase_units(cfg_widths, ptype, phase_q));
  assign phase_end  = unit_tick && (ucnt_q == lim);
  assign last_sym   = (sym_q == SK_TAIL) ||
                      (sym_q == SK_DATA && bitcnt_q == cfg_nbits && !cfg_tail_en);
  assign frame_done = (state_q == ST_RUN) && phase_end && phase_q && last_sym;
  assign gap_done   = (state_q == ST_GAP) && phase_end;
  assign can_start  = tx_en && !fifo_empty;
  assign start_ev   = can_start &&
                      ((state_q == ST_IDLE) || (frame_done && cfg_cont) || gap_done);
  assign underrun   = frame_done && cfg_cont && tx_en && fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sym_q    <= SK_HEAD;
      phase_q  <= 1'b0;
      ucnt_q   <= '0;
      bitcnt_q <= '0;
      shreg_q  <= '0;
    end else if (start_ev) begin
      state_q  <= ST_RUN;
      sym_q    <= cfg_head_en ? SK_HEAD : SK_DATA;
      phase_q  <= 1'b0;
      ucnt_q   <= '0;
      bitcnt_q <= '0;
      shreg_q  <= fifo_rd & entry_mask(cfg_fifo_w);
    end else if (frame_done) begin
      state_q <= cfg_cont ? ST_IDLE : ST_GAP;
      phase_q <= 1'b0;
      ucnt_q  <= '0;
    end else if (gap_done) begin
      state_q <= ST_IDLE;
      ucnt_q  <= '0;
    end else if (state_q == ST_RUN && phase_end) begin
      ucnt_q <= '0;
      if (!phase_q) begin
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        case (sym_q)
          SK_HEAD: begin
            sym_q    <= SK_DATA;
            bitcnt_q <= '0;
          end
          SK_DATA: begin
            if (bitcnt_q == cfg_nbits) begin
              sym_q <= SK_TAIL;
            end else begin
              bitcnt_q <= bitcnt_q + 5'd1;
              shreg_q  <= shreg_q >> 1;
            end
          end
          default: sym_q <= SK_TAIL;
        endcase
      end
    end else if (unit_tick) begin
      ucnt_q <= ucnt_q + GAP_W'(1);
    end
  end

  // ---------------- output path ----------------
  logic mark, car;
  assign mark = (state_q == ST_RUN) && (!phase_q ^ cfg_inv[ptype]);

  irpw_carrier #(.LW(FIELD_W)) u_car (
    .clk(clk), .rst_n(rst_n), .en(mark),
    .hi_len(cfg_mod_hi), .lo_len(cfg_mod_lo), .car(car)
  );

  assign ir_out = cfg_out_inv ^ (mark & (cfg_mod_en ? car : 1'b1));
  assign busy   = (state_q != ST_IDLE);

  // ---------------- flags ----------------
  logic end_q, err_q, thr;
  logic err_set;
  assign err_set = (in_valid && fifo_full) || underrun;
  assign thr     = (fifo_cnt <= cfg_thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (frame_done)      end_q <= 1'b1;
      else if (int_clr[0]) end_q <= 1'b0;
      if (err_set)         err_q <= 1'b1;
      else if (int_clr[2]) err_q <= 1'b0;
    end
  end

  assign int_sts = {err_q, thr, end_q};
  assign irq     = |(int_sts & cfg_int_en);

  // ---------------- assertions ----------------
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN) |-> (ir_out == cfg_out_inv)); // R4
  AST_UNIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (ucnt_q <= lim)); // R2
  AST_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> int_sts[0]); // R11
  AST_GAP_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !cfg_cont) |=> (state_q == ST_GAP)); // R5
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !tx_en) |=> (state_q == ST_IDLE)); // R13

endmodule

// File: tb/irpw_tx_tb_top.sv
`timescale 1ns/1ps
module irpw_tx_tb_top;

  typedef struct packed {
    logic [15:0] unit;
    logic [63:0] w;
    logic [3:0]  inv;
    logic        he;
    logic        te;
    logic [4:0]  nb;
    logic [1:0]  fw;
    logic        oi;
    logic        ct;
    logic        me;
    logic [7:0]  mh;
    logic [7:0]  ml;
    logic [31:0] d0;
    logic [31:0] d1;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{16'd1, 64'h00_01_02_00_00_00_01_03, 4'b0000, 1'b1, 1'b1, 5'd11, 2'd0, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 32'h0000_0FA5, 32'h1234_5603},
    '{16'd0, 64'h01_02_00_01_01_00_00_02, 4'b1010, 1'b1, 1'b0, 5'd3,  2'd1, 1'b1, 1'b1, 1'b0, 8'd0, 8'd0, 32'h0000_00F6, 32'h0000_0009},
    '{16'd2, 64'h00_01_01_00_00_01_00_02, 4'b0001, 1'b1, 1'b1, 5'd4,  2'd3, 1'b0, 1'b0, 1'b1, 8'd1, 8'd0, 32'h0000_0015, 32'h0000_000A},
    '{16'd0, 64'h00_00_00_01_01_00_00_00, 4'b0000, 1'b0, 1'b0, 5'd31, 2'd3, 1'b0, 1'b1, 1'b1, 8'd0, 8'd1, 32'h8000_0001, 32'hFFFF_0000},
    '{16'd3, 64'h02_00_01_01_00_01_01_00, 4'b1111, 1'b1, 1'b1, 5'd0,  2'd2, 1'b1, 1'b0, 1'b0, 8'd0, 8'd0, 32'h0000_0001, 32'h00FF_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_unit = '0;
  logic [63:0] cfg_widths = '0;
  logic [3:0]  cfg_inv = '0;
  logic        cfg_head_en = 1'b0, cfg_tail_en = 1'b0;
  logic [4:0]  cfg_nbits = '0;
  logic [1:0]  cfg_fifo_w = '0;
  logic        cfg_out_inv = 1'b0, cfg_cont = 1'b0, cfg_mod_en = 1'b0;
  logic [7:0]  cfg_mod_hi = '0, cfg_mod_lo = '0;
  logic [2:0]  cfg_thresh = 3'd2;
  logic [2:0]  cfg_int_en = '0, int_clr = '0;
  logic        tx_en = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready, ir_out, busy, irq;
  logic [2:0]  fifo_cnt, int_sts;

  always #2.5 clk = ~clk;

  irpw_tx dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_unit(cfg_unit), .cfg_widths(cfg_widths),
    .cfg_inv(cfg_inv), .cfg_head_en(cfg_head_en), .cfg_tail_en(cfg_tail_en),
    .cfg_nbits(cfg_nbits), .cfg_fifo_w(cfg_fifo_w), .cfg_out_inv(cfg_out_inv),
    .cfg_cont(cfg_cont), .cfg_mod_en(cfg_mod_en), .cfg_mod_hi(cfg_mod_hi),
    .cfg_mod_lo(cfg_mod_lo), .cfg_thresh(cfg_thresh), .cfg_int_en(cfg_int_en),
    .int_clr(int_clr), .tx_en(tx_en), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .ir_out(ir_out), .busy(busy), .fifo_cnt(fifo_cnt),
    .int_sts(int_sts), .irq(irq)
  );

  int n_chk = 0;
  int n_err = 0;
  bit expq[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_word(input logic [31:0] d);
    @(negedge clk);
    in_data  = d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // one pulse: phase 0 active unless swapped, lengths from byte fields
  task automatic add_pulse(input logic [63:0] w, input int pt, input bit sw, input int u);
    int l0, l1;
    l0 = (int'(w[pt*16 +: 8]) + 1) * (u + 1);
    l1 = (int'(w[pt*16 + 8 +: 8]) + 1) * (u + 1);
    for (int i = 0; i < l0; i++) expq.push_back(!sw);
    for (int i = 0; i < l1; i++) expq.push_back(sw);
  endtask

  task automatic add_frame(input vec_t v, input logic [31:0] d);
    logic [31:0] md;
    int u;
    u  = int'(v.unit);
    md = (v.fw == 2'd3) ? d : (d & ((32'h1 << (8 * (int'(v.fw) + 1))) - 32'h1));
    if (v.he) add_pulse(v.w, 0, v.inv[0], u);
    for (int b = 0; b <= int'(v.nb); b++) begin
      int pt;
      pt = md[b] ? 2 : 1;
      add_pulse(v.w, pt, v.inv[pt], u);
    end
    if (v.te) add_pulse(v.w, 3, v.inv[3], u);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int mism, first_bad, run, gap;
    bit e, lvl;
    @(negedge clk);
    tx_en = 1'b0;
    cfg_unit = v.unit; cfg_widths = v.w; cfg_inv = v.inv;
    cfg_head_en = v.he; cfg_tail_en = v.te; cfg_nbits = v.nb; cfg_fifo_w = v.fw;
    cfg_out_inv = v.oi; cfg_cont = v.ct; cfg_mod_en = v.me;
    cfg_mod_hi = v.mh; cfg_mod_lo = v.ml;
    push_word(v.d0);
    push_word(v.d1);
    expq.delete();
    add_frame(v, v.d0);
    if (!v.ct) begin
      gap = (int'(v.w[55:48]) + int'(v.w[63:56]) + 2) * (int'(v.unit) + 1);
      for (int i = 0; i < gap; i++) expq.push_back(1'b0);
    end
    add_frame(v, v.d1);
    for (int i = 0; i < 4; i++) expq.push_back(1'b0);
    @(negedge clk);
    tx_en = 1'b1;
    @(posedge clk);
    mism = 0; first_bad = -1; run = 0;
    for (int i = 0; i < expq.size(); i++) begin
      @(negedge clk);
      run = expq[i] ? run + 1 : 0;
      lvl = expq[i] && (!v.me || (((run - 1) % (int'(v.mh) + int'(v.ml) + 2)) < int'(v.mh) + 1));
      e = v.oi ^ lvl;
      if (ir_out !== e) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    end
    // waveform: R1 order, R2 lengths, R3 swaps, R4 levels, R5 gap, R6 carrier, R7 masking, R13 start
    chk(mism == 0, $sformatf("R1 R2 R3 R4 R5 R6 R7 R13 vector %0d mismatches (first at %0d)", idx, first_bad),
        mism, 0);
    tx_en = 1'b0;
    while (busy) @(negedge clk);
    chk(int_sts[0] == 1'b1, "R11 end flag after frames", int_sts[0], 1);
    chk(int_sts[2] == v.ct, "R10 underrun only in back-to-back mode", int_sts[2], v.ct);
    int_clr = 3'b101;
    @(negedge clk);
    int_clr = 3'b000;
    chk(int_sts[0] == 1'b0 && int_sts[2] == 1'b0, "R11 flags cleared", int_sts, 3'b010);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ir_out == 1'b0, "R4 idle level after reset", ir_out, 0);
    chk(in_ready == 1'b1 && fifo_cnt == 3'd0, "R8 empty FIFO after reset", {in_ready, fifo_cnt}, 4'b1000);
    chk(int_sts == 3'b010, "R9 flags after reset", int_sts, 3'b010);
    chk(irq == 1'b0, "R12 irq with nothing enabled", irq, 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

    // FIFO fill, overflow, threshold, interrupt, enable low
    cfg_out_inv = 1'b1;
    cfg_thresh  = 3'd2;
    cfg_int_en  = 3'b000;
    for (int i = 0; i < 4; i++) push_word(32'h100 + 32'(i));
    chk(in_ready == 1'b0 && fifo_cnt == 3'd4, "R8 full after four writes", {in_ready, fifo_cnt}, 4'b0100);
    chk(int_sts[1] == 1'b0, "R9 threshold flag low above level", int_sts[1], 0);
    chk(int_sts[2] == 1'b0, "R10 no error before overflow", int_sts[2], 0);
    push_word(32'hDEAD);
    chk(int_sts[2] == 1'b1, "R10 write while full sets error", int_sts[2], 1);
    chk(fifo_cnt == 3'd4, "R8 dropped write leaves count", fifo_cnt, 4);
    repeat (10) @(negedge clk);
    chk(ir_out == 1'b1 && busy == 1'b0 && fifo_cnt == 3'd4, "R13 tx_en low keeps idle",
        {ir_out, busy, fifo_cnt}, 5'b10100);
    chk(irq == 1'b0, "R12 irq masked", irq, 0);
    cfg_int_en = 3'b100;
    @(negedge clk);
    chk(irq == 1'b1, "R12 irq from error flag", irq, 1);
    int_clr = 3'b100;
    @(negedge clk);
    int_clr = 3'b000;
    chk(int_sts[2] == 1'b0 && irq == 1'b0, "R10 error cleared", {int_sts[2], irq}, 0);
    cfg_thresh = 3'd4;
    @(negedge clk);
    chk(int_sts[1] == 1'b1, "R9 threshold flag at level", int_sts[1], 1);
    cfg_int_en = 3'b010;
    @(negedge clk);
    chk(irq == 1'b1, "R12 irq from threshold flag", irq, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule